// File: doc/BRIEF.md
# Complementary Gate-Drive Sequencer

This block turns a per-period start strobe and a few synchronous comparator results into two gate commands for an active-clamp forward stage: a main-switch drive (active high) and a clamp-switch drive (active low). Every handover between the two switches waits for a programmable number of clock ticks with both switches off, on the rising edge of the main drive and on its falling edge alike.

The main on-interval ends when the PWM comparator or the peak-limit comparator reports a trip, whichever comes first. A minimum on-time and a maximum on-time are enforced, both counted in ticks. Two blanking windows mask comparators after switching edges. The forward window opens at each main turn-on and masks both forward comparators. The reverse window opens at each clamp turn-on and masks the reverse-current comparator, which is otherwise heeded only while the clamp conducts and ends the clamp interval when it trips. Dead time, minimum on-time and maximum on-time are sampled once per period, at the accepted start strobe. Dropping the enable forces both drives to their off levels in the same cycle.

Top module: `cpwm_sequencer`

## Requirements
- R1: While reset is asserted, or in the same cycle that `en` is low, `main_drv` is 0, `aux_drv_n` is 1 (clamp off), and both blanking outputs are 0.
- R2: After an accepted start strobe, the clamp goes off on the next clock edge, and the main drive goes high D edges later, with D = `dead_ticks`, or 1 when `dead_ticks` is 0.
- R3: After the main drive falls, both switches stay off for exactly D ticks before `aux_drv_n` goes low.
- R4: A high level on `pwm_trip` or `peak_trip`, sampled on an edge outside the forward blanking window, ends the main on-interval on that edge, provided the minimum on-time has been reached.
- R5: `fwd_blank` is high for exactly BLANK_TICKS ticks after each main turn-on. Forward trips seen in that window are discarded and are not remembered.
- R6: A valid forward trip that comes before `min_on_ticks` ticks of on-time is held. The main drive then falls after exactly `min_on_ticks` ticks.
- R7: The main drive never stays high for more than `max_on_ticks` ticks (at least 1). It falls after that many ticks even if no trip arrives.
- R8: `rev_blank` is high for exactly BLANK_TICKS ticks after each clamp turn-on. A high `rev_trip` outside that window, while the clamp is on, turns the clamp off on that edge. `rev_trip` has no effect while the main switch is on or while the reverse window is open.
- R9: `main_drv` high and `aux_drv_n` low never occur together.
- R10: The settings are latched only when a start strobe is accepted, so later changes to them do not affect the current period. A start strobe is accepted only when idle, in the trailing dead time or while the clamp is on, and an accepted strobe ends the clamp interval. A strobe during the leading dead time or the main on-interval is ignored.
- R11: While `en` is low, start strobes are ignored and the sequencer restarts from idle, with no leading dead-time wait counted from the earlier clamp interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable. When low, both drives are forced off at once |
| cyc_start | input | 1 | One-tick strobe that starts a switching period |
| pwm_trip | input | 1 | PWM comparator result, synchronous |
| peak_trip | input | 1 | Peak-current-limit comparator result, synchronous |
| rev_trip | input | 1 | Reverse-current comparator result, synchronous |
| dead_ticks | input | TICK_W | Dead time on both edges, in ticks |
| min_on_ticks | input | TICK_W | Minimum main on-time, in ticks |
| max_on_ticks | input | TICK_W | Maximum main on-time, in ticks |
| main_drv | output | 1 | Main switch gate command, active high |
| aux_drv_n | output | 1 | Clamp switch gate command, active low |
| fwd_blank | output | 1 | Forward comparator blanking window |
| rev_blank | output | 1 | Reverse comparator blanking window |

## Verification
The embedded properties assume that every comparator input and the start strobe are synchronous to `clk` and stable around its rising edge. They also assume that BLANK_TICKS fits in TICK_W bits. Nothing is assumed about when `en` falls, because the properties about disable-to-idle and non-overlap must hold for a drop in any state. The stimulus changes every input only on the falling clock edge. It always leaves enough room in the switching period for both dead times, the on-interval and a clamp interval longer than the reverse window. It drops `en` in the middle of an on-interval, at an arbitrary point.

// File: rtl/cpwm_sequencer.sv
`timescale 1ns/1ps
module cpwm_sequencer #(
  parameter int TICK_W      = 8,
  parameter int BLANK_TICKS = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cyc_start,
  input  logic              pwm_trip,
  input  logic              peak_trip,
  input  logic              rev_trip,
  input  logic [TICK_W-1:0] dead_ticks,
  input  logic [TICK_W-1:0] min_on_ticks,
  input  logic [TICK_W-1:0] max_on_ticks,
  output logic              main_drv,
  output logic              aux_drv_n,
  output logic              fwd_blank,
  output logic              rev_blank
);
  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_ON, S_TRAIL, S_CLAMP} st_t;

  localparam logic [TICK_W-1:0] BLK     = BLANK_TICKS[TICK_W-1:0];
  localparam logic [TICK_W-1:0] CNT_TOP = '1;
  localparam logic [TICK_W:0]   ONE     = {{TICK_W{1'b0}}, 1'b1};

  st_t               st;
  logic [TICK_W-1:0] cnt, dt_q, mn_q, mx_q;
  logic              pend, main_q, aux_n_q;

  logic [TICK_W:0] nxt;
  logic in_fb, in_rb, fwd_hit, hit_min, hit_max, end_on, rev_ok, start_ok, dt_done;

  assign nxt      = {1'b0, cnt} + ONE;
  assign dt_done  = nxt >= {1'b0, dt_q};
  assign in_fb    = (st == S_ON)    && (cnt < BLK);
  assign in_rb    = (st == S_CLAMP) && (cnt < BLK);
  assign fwd_hit  = (st == S_ON) && (pwm_trip || peak_trip) && !in_fb;
  assign hit_min  = nxt >= {1'b0, mn_q};
  assign hit_max  = nxt >= {1'b0, mx_q};
  assign end_on   = hit_max || ((pend || fwd_hit) && hit_min);
  assign rev_ok   = rev_trip && (st == S_CLAMP) && !in_rb;
  assign start_ok = cyc_start && (st == S_IDLE || st == S_TRAIL || st == S_CLAMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; pend <= 1'b0;
      main_q <= 1'b0; aux_n_q <= 1'b1;
      dt_q <= ONE[TICK_W-1:0]; mn_q <= '0; mx_q <= ONE[TICK_W-1:0];
    end else if (!en) begin
      st <= S_IDLE; cnt <= '0; pend <= 1'b0;
      main_q <= 1'b0; aux_n_q <= 1'b1;
    end else if (start_ok) begin
      st      <= S_LEAD;
      cnt     <= '0;
      pend    <= 1'b0;
      aux_n_q <= 1'b1;
      dt_q    <= (dead_ticks == '0)   ? ONE[TICK_W-1:0] : dead_ticks;
      mn_q    <= min_on_ticks;
      mx_q    <= (max_on_ticks == '0) ? ONE[TICK_W-1:0] : max_on_ticks;
    end else begin
      case (st)
        S_LEAD:
          if (dt_done) begin st <= S_ON; main_q <= 1'b1; cnt <= '0; end
          else cnt <= nxt[TICK_W-1:0];
        S_ON:
          if (end_on) begin
            st <= S_TRAIL; main_q <= 1'b0; cnt <= '0; pend <= 1'b0;
          end else begin
            cnt  <= nxt[TICK_W-1:0];
            pend <= pend || fwd_hit;
          end
        S_TRAIL:
          if (dt_done) begin st <= S_CLAMP; aux_n_q <= 1'b0; cnt <= '0; end
          else cnt <= nxt[TICK_W-1:0];
        S_CLAMP:
          if (rev_ok) begin st <= S_IDLE; aux_n_q <= 1'b1; cnt <= '0; end
          else if (cnt != CNT_TOP) cnt <= nxt[TICK_W-1:0];
        default: ;
      endcase
    end
  end

  assign main_drv  = main_q && en;
  assign aux_drv_n = aux_n_q || !en;
  assign fwd_blank = in_fb && en;
  assign rev_blank = in_rb && en;

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_drv && !aux_drv_n));
  p_disable_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st == S_IDLE) && !main_q && aux_n_q);
  p_main_after_clamp_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_q) |-> $past(aux_n_q));
  p_clamp_after_main_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aux_n_q) |-> !$past(main_q));
  p_max_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ON) |-> ({1'b0, cnt} < {1'b0, mx_q}));
  p_min_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(main_q) && $past(en) |-> $past(hit_min) || $past(hit_max));
  p_fwd_blank_main_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_blank |-> main_drv);
  p_rev_blank_clamp_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rev_blank |-> !aux_drv_n);
endmodule

// File: tb/tb_cpwm_sequencer.sv
`timescale 1ns/1ps
module tb_cpwm_sequencer;
  localparam int TW = 8;
  localparam int BLANK = 4;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cyc_start = 1'b0;
  logic pwm_trip = 1'b0, peak_trip = 1'b0, rev_trip = 1'b0;
  logic [TW-1:0] dead_ticks = '0, min_on_ticks = '0, max_on_ticks = '0;
  logic main_drv, aux_drv_n, fwd_blank, rev_blank;

  cpwm_sequencer #(.TICK_W(TW), .BLANK_TICKS(BLANK)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cyc_start(cyc_start),
    .pwm_trip(pwm_trip), .peak_trip(peak_trip), .rev_trip(rev_trip),
    .dead_ticks(dead_ticks), .min_on_ticks(min_on_ticks), .max_on_ticks(max_on_ticks),
    .main_drv(main_drv), .aux_drv_n(aux_drv_n), .fwd_blank(fwd_blank), .rev_blank(rev_blank));

  always #2 clk = ~clk;

  typedef struct { int kind; int val; string req; } ev_t;
  ev_t exp_q[$];
  int nchk = 0, nfail = 0;
  bit done = 0, mon_on = 0, have_clamp = 0;
  int carry = 0;

  task automatic chk(string req, int act, int exp_v);
    nchk++;
    if (act != exp_v) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic push(int kind, int val, string req);
    ev_t e;
    e.kind = kind; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic pop_cmp(int kind, int act);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk("R9 unexpected event", kind, -1);
    end else begin
      e = exp_q.pop_front();
      chk({e.req, " kind"}, kind, e.kind);
      chk(e.req, act, e.val);
    end
  endtask

  // Monitor: samples one ns after each falling edge.
  // Event kinds: 0 = leading gap, 1 = main width, 2 = trailing gap, 3 = clamp width.
  logic p_main = 1'b0, p_aux = 1'b1, p_fb = 1'b0, p_rb = 1'b0;
  int on_run = 0, off_run = 0, cl_run = 0, fb_run = 0, rb_run = 0;
  bit clamp_seen = 0;
  initial forever begin
    @(negedge clk); #1;
    if (mon_on) begin
      if (main_drv && !aux_drv_n) chk("R9 overlap", 1, 0);
      if (main_drv && !p_main) begin
        if (clamp_seen) pop_cmp(0, off_run);
        clamp_seen = 0;
      end
      if (!main_drv && p_main) pop_cmp(1, on_run);
      if (!aux_drv_n && p_aux) begin pop_cmp(2, off_run); clamp_seen = 1; end
      if (aux_drv_n && !p_aux) pop_cmp(3, cl_run);
      if (!fwd_blank && p_fb && main_drv) chk("R5 fwd blank width", fb_run, BLANK);
      if (!rev_blank && p_rb && !aux_drv_n) chk("R8 rev blank width", rb_run, BLANK);
      on_run  = main_drv ? on_run + 1 : 0;
      off_run = (!main_drv && aux_drv_n) ? off_run + 1 : 0;
      cl_run  = !aux_drv_n ? cl_run + 1 : 0;
      fb_run  = fwd_blank ? fb_run + 1 : 0;
      rb_run  = rev_blank ? rb_run + 1 : 0;
      p_main = main_drv; p_aux = aux_drv_n; p_fb = fwd_blank; p_rb = rev_blank;
    end
  end

  function automatic bit hit(int t, int at, bit lvl, int p);
    if (at < 0) return 1'b0;
    return lvl ? (t >= at && t < p) : (t == at);
  endfunction

  task automatic period(int d, int mn, int mx, int p,
                        int pwm_t, bit pwm_l, int peak_t, bit peak_l,
                        int rev_t, bit rev_l, int xtra_t, int stop_t,
                        string rq_on, string rq_cl);
    int de, mxe, w, ec, cl, aoff;
    bit pend;
    de  = (d == 0) ? 1 : d;
    mxe = (mx == 0) ? 1 : mx;
    if (have_clamp) push(0, carry + de, "R2 leading dead time");
    pend = 0; w = 0;
    for (int j = 1; j <= mxe; j++) begin
      int t = de + j;
      bit trip = hit(t, pwm_t, pwm_l, p) || hit(t, peak_t, peak_l, p);
      if (j - 1 >= BLANK && trip) pend = 1;
      if (j >= mxe || (pend && j >= mn)) begin w = j; break; end
    end
    if (stop_t >= 0 && stop_t <= de + w) begin
      push(1, stop_t - 1 - de, rq_on);
      have_clamp = 0;
    end else begin
      push(1, w, rq_on);
      push(2, de, "R3 trailing dead time");
      ec = 2 * de + w; cl = 0; aoff = p;
      for (int k = 1; k < 256; k++) begin
        int t = ec + k;
        if (t >= p) begin cl = p - ec; aoff = p; break; end
        if (k - 1 >= BLANK && hit(t, rev_t, rev_l, p)) begin cl = k; aoff = t; break; end
      end
      push(3, cl, rq_cl);
      carry = p - aoff;
      have_clamp = 1;
    end
    for (int t = 0; t < p; t++) begin
      @(negedge clk);
      cyc_start    = (t == 0) || (t == xtra_t);
      dead_ticks   = (t == 0) ? 8'(d)  : 8'(d + 5);
      min_on_ticks = (t == 0) ? 8'(mn) : 8'(0);
      max_on_ticks = (t == 0) ? 8'(mx) : 8'(2);
      pwm_trip  = hit(t, pwm_t, pwm_l, p);
      peak_trip = hit(t, peak_t, peak_l, p);
      rev_trip  = hit(t, rev_t, rev_l, p);
      if (stop_t >= 0 && t >= stop_t) en = 1'b0;
      if (stop_t >= 0 && t == stop_t) begin
        #1;
        chk("R1 main off on disable", int'(main_drv), 0);
        chk("R1 clamp off on disable", int'(aux_drv_n), 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset main", int'(main_drv), 0);
    chk("R1 reset aux", int'(aux_drv_n), 1);
    chk("R1 reset blanks", int'(fwd_blank | rev_blank), 0);
    @(negedge clk);
    rst_n = 1'b1; en = 1'b1; mon_on = 1;
    repeat (3) @(negedge clk);
    //      d  mn  mx   p  pwm_t l  peak_t l  rev_t l  xtra stop
    period(3,  2, 30, 60,   13, 1,    -1, 0,   -1, 0,   -1,  -1, "R4 pwm end",      "R10 clamp ends at start");
    period(3,  2, 20, 60,   -1, 0,     6, 0,   -1, 0,    5,  -1, "R5 R10 blanked",  "R10 clamp ends at start");
    period(2, 12, 30, 60,    8, 0,    -1, 0,   -1, 0,   -1,  -1, "R6 min on",       "R10 clamp ends at start");
    period(4,  2,  9, 60,   -1, 0,    -1, 0,   27, 1,   -1,  -1, "R7 max on",       "R8 reverse end");
    period(1,  2, 30, 50,   -1, 0,     8, 1,    3, 0,   -1,  -1, "R4 peak end",     "R8 rev ignored in on");
    period(0,  2,  6, 40,   -1, 0,    -1, 0,   10, 0,   -1,  -1, "R7 max on",       "R8 rev ignored in blank");
    period(3,  2, 30, 40,   -1, 0,    -1, 0,   -1, 0,   -1,  15, "R1 disabled in on", "R1 none");
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      cyc_start = (i % 4 == 0);
      #1;
      chk("R11 start ignored main", int'(main_drv), 0);
      chk("R11 start ignored aux", int'(aux_drv_n), 1);
    end
    @(negedge clk); cyc_start = 1'b0; en = 1'b1;
    repeat (3) @(negedge clk);
    period(2,  2,  7, 40,   -1, 0,    -1, 0,   -1, 0,   -1,  -1, "R11 R7 restart",  "R10 clamp ends at start");
    @(negedge clk); cyc_start = 1'b1;
    @(negedge clk); cyc_start = 1'b0; en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 all expected events seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog R9 actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule